// File: doc/BRIEF.md
# Block Parity Codec (row and column parity)

This block protects a fixed-length block of 8-bit characters with parity in two directions. The transmit path adds a parity bit to every character, producing 9-bit rows. After a parameterized number of characters it inserts one extra row, the check row. Each of the check row's eight low bits is the parity of one data-bit column across the block. Bit 8 of the check row is that row's own parity bit.

The receive path takes the same stream of rows, data rows first and then the check row. It recomputes parity in both directions. One cycle after the check row it pulses a completion strobe and presents:
- a per-row error bitmap,
- an 8-bit column error vector,
- a flag for a bad parity bit on the check row,
- a single summary flag.

Row parity alone misses an even number of flips inside one character. Such flips still show up in the column vector.

Both paths use byte-level valid/ready handshakes. The parity sense and the block length are parameters. The same sense applies to rows and to columns. A synchronous reset discards any partial block on either path without reporting it.

Top module: `blk_parity_codec`

## Requirements
- R1: Every transmitted data row is `{p, d}`, with the character `d` in bits 7:0 and `p` in bit 8. `p` is chosen so that the 9-bit row holds an odd count of ones when `ODD_SENSE`=1, or an even count when `ODD_SENSE`=0. With even sense, `d`=0x01 gives `p`=1 and `d`=0x03 gives `p`=0.
- R2: While `tx_out_valid` is high and `tx_out_ready` is low, the transmit output row and its check flag stay unchanged. A character is taken only in a cycle where `tx_in_valid` and `tx_in_ready` are both high.
- R3: After `BLK_LEN` data rows have been handed out, the next row handed out is the check row, marked by `tx_out_chk`=1. `tx_in_ready` stays low from the moment the block's last character is taken until the check row is loaded.
- R4: Bit c (0..7) of the check row makes column c obey the parity sense. Column c is bit c of every data row in the block plus the check bit. Bit 8 of the check row is its own row parity bit under the R1 rule.
- R5: On receive, a data row whose 9 bits break the parity sense sets bit k of `rx_row_err`, where k is the row's position in the block (0 = first row). A single flipped data bit also sets the matching bit of `rx_col_err`.
- R6: Two flipped data bits in one received row leave that row's `rx_row_err` bit clear and set exactly the two affected bits of `rx_col_err`.
- R7: `rx_done` is high for exactly one cycle, the cycle after the check row is accepted. `rx_row_err`, `rx_col_err`, `rx_chk_err` and `rx_any_err` update with it and hold until the next `rx_done`. `rx_any_err` is the OR of all the error bits.
- R8: A block with correct parity everywhere reports all error outputs as zero.
- R9: A synchronous low on `rst_n` clears all outputs and counters. It aborts a partial block on either path: no report is made for it, and the next rows start a fresh block with fresh accumulators.
- R10: A check row whose own 9 bits break the parity sense sets `rx_chk_err` and `rx_any_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_in_valid | input | 1 | Character offered to the transmit path |
| tx_in_data | input | 8 | Character value |
| tx_in_ready | output | 1 | Transmit path takes the character this cycle |
| tx_out_valid | output | 1 | Output row is valid |
| tx_out_row | output | 9 | Output row: bit 8 parity, bits 7:0 data or column checks |
| tx_out_chk | output | 1 | Output row is the check row |
| tx_out_ready | input | 1 | Downstream accepts the output row |
| rx_in_valid | input | 1 | Received row offered |
| rx_in_row | input | 9 | Received row, same layout as `tx_out_row` |
| rx_in_ready | output | 1 | Receive path accepts a row (always high) |
| rx_done | output | 1 | One-cycle pulse after the check row |
| rx_row_err | output | BLK_LEN | Per-row parity error bitmap |
| rx_col_err | output | 8 | Per-column parity error vector |
| rx_chk_err | output | 1 | Check row's own parity bit is wrong |
| rx_any_err | output | 1 | Any error in the reported block |

## Verification
The receive-side assertions assume that the sender frames rows correctly. The receiver therefore treats the row after every `BLK_LEN` data rows as the check row, and it has no separate marker to tell them apart. The bench keeps to this by always driving whole blocks, except where it breaks a block on purpose with a reset. The hold assertion on the transmit output assumes that `tx_out_ready` is only a level and carries no meaning while no row is valid. The bench toggles `tx_out_ready` freely to cover stalls on both data rows and check rows. All assertions take reset to be low from time zero.

// File: rtl/bpar_pkg.sv
// Package: shared widths and parity helpers for the block parity codec.
// Assumes a character is CHAR_W bits and a row adds one parity bit on top.
package bpar_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned ROW_W  = CHAR_W + 1;

    // Parity bit that makes {bit, d} obey the sense (odd when odd_s is 1).
    function automatic logic sense_bit(input logic [CHAR_W-1:0] d, input logic odd_s);
        return (^d) ^ odd_s;
    endfunction

    // True when a full row breaks the parity sense.
    function automatic logic row_bad(input logic [ROW_W-1:0] r, input logic odd_s);
        return (^r) != odd_s;
    endfunction
endpackage

// File: rtl/bpar_col_acc.sv
// Column parity accumulator: one register per data column, seeded with the
// parity sense at the start of each block and XOR-folded with every row.
// Assumes the caller raises 'first' on the first row of each block.
module bpar_col_acc
    import bpar_pkg::*;
#(
    parameter bit ODD_SENSE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              first,
    input  logic [CHAR_W-1:0] din,
    output logic [CHAR_W-1:0] acc
);
    genvar c;
    generate
        for (c = 0; c < CHAR_W; c++) begin : g_col
            logic bit_q;
            // Fold one column bit; restart from the seed on a block's first row.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= ODD_SENSE;
                end else if (en) begin
                    bit_q <= (first ? ODD_SENSE : bit_q) ^ din[c];
                end
            end
            assign acc[c] = bit_q;
        end
    endgenerate
endmodule

// File: rtl/bpar_tx.sv
// Transmit path: adds a row parity bit to each character and, after BLK_LEN
// characters, inserts a check row built from the column accumulators.
// Assumes a downstream valid/ready handshake; a single output register.
module bpar_tx
    import bpar_pkg::*;
#(
    parameter bit          ODD_SENSE = 1'b1,
    parameter int unsigned BLK_LEN   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [ROW_W-1:0]  out_row,
    output logic              out_chk,
    input  logic              out_ready
);
    localparam int unsigned     CNT_W = $clog2(BLK_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_LEN);

    logic [CNT_W-1:0]  cnt_q;
    logic              ov_q;
    logic              chk_q;
    logic [ROW_W-1:0]  row_q;
    logic [CHAR_W-1:0] col_w;
    logic              can_load;
    logic              chk_due;
    logic              take;

    // Handshake decode: the output slot is free or drains this cycle.
    always_comb begin
        can_load = !ov_q || out_ready;
        chk_due  = (cnt_q == LAST);
        in_ready = can_load && !chk_due;
        take     = in_valid && in_ready;
    end

    bpar_col_acc #(.ODD_SENSE(ODD_SENSE)) u_cols (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (take),
        .first(cnt_q == '0),
        .din  (in_data),
        .acc  (col_w)
    );

    // Output register: loads a check row when due, otherwise the next character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q  <= 1'b0;
            chk_q <= 1'b0;
            row_q <= '0;
            cnt_q <= '0;
        end else if (can_load) begin
            if (chk_due) begin
                ov_q  <= 1'b1;
                chk_q <= 1'b1;
                row_q <= {sense_bit(col_w, ODD_SENSE), col_w};
                cnt_q <= '0;
            end else if (in_valid) begin
                ov_q  <= 1'b1;
                chk_q <= 1'b0;
                row_q <= {sense_bit(in_data, ODD_SENSE), in_data};
                cnt_q <= cnt_q + 1'b1;
            end else begin
                ov_q  <= 1'b0;
            end
        end
    end

    assign out_valid = ov_q;
    assign out_row   = row_q;
    assign out_chk   = chk_q;

    assert_row_sense_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !row_bad(out_row, ODD_SENSE));
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_chk)));
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    assert_no_take_when_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (cnt_q == LAST || cnt_q == '0));
endmodule

// File: rtl/bpar_rx.sv
// Receive path: checks each data row's parity, folds columns, and on the check
// row compares columns and reports the block one cycle later.
// Assumes rows arrive framed: BLK_LEN data rows, then exactly one check row.
module bpar_rx
    import bpar_pkg::*;
#(
    parameter bit          ODD_SENSE = 1'b1,
    parameter int unsigned BLK_LEN   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ROW_W-1:0]   in_row,
    output logic               done,
    output logic [BLK_LEN-1:0] row_err,
    output logic [CHAR_W-1:0]  col_err,
    output logic               chk_err,
    output logic               any_err
);
    localparam int unsigned     CNT_W = $clog2(BLK_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_LEN);

    logic [CNT_W-1:0]   idx_q;
    logic [BLK_LEN-1:0] racc_q;
    logic [BLK_LEN-1:0] racc_d;
    logic [CHAR_W-1:0]  col_w;
    logic [CHAR_W-1:0]  col_diff;
    logic               at_chk;
    logic               data_take;

    // Row position decode for the incoming row.
    always_comb begin
        at_chk    = (idx_q == LAST);
        data_take = in_valid && !at_chk;
        col_diff  = col_w ^ in_row[CHAR_W-1:0];
    end

    // Next row-error bitmap: clear on a block's first row, set the current slot.
    always_comb begin
        racc_d = racc_q;
        for (int i = 0; i < BLK_LEN; i++) begin
            if (data_take && idx_q == '0) begin
                racc_d[i] = 1'b0;
            end
            if (data_take && idx_q == CNT_W'(i)) begin
                racc_d[i] = row_bad(in_row, ODD_SENSE);
            end
        end
    end

    bpar_col_acc #(.ODD_SENSE(ODD_SENSE)) u_cols (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (data_take),
        .first(idx_q == '0),
        .din  (in_row[CHAR_W-1:0]),
        .acc  (col_w)
    );

    // Row index, bitmap and block report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            racc_q  <= '0;
            done    <= 1'b0;
            row_err <= '0;
            col_err <= '0;
            chk_err <= 1'b0;
            any_err <= 1'b0;
        end else begin
            done   <= 1'b0;
            racc_q <= racc_d;
            if (in_valid) begin
                if (at_chk) begin
                    idx_q   <= '0;
                    done    <= 1'b1;
                    row_err <= racc_q;
                    col_err <= col_diff;
                    chk_err <= row_bad(in_row, ODD_SENSE);
                    any_err <= (|racc_q) || (|col_diff) || row_bad(in_row, ODD_SENSE);
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && at_chk));
    assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);
    assert_quiet_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!done && !any_err));
endmodule

// File: rtl/blk_parity_codec.sv
// Top: row-and-column parity codec with independent transmit and receive paths
// sharing one parity sense and block length.
// Assumes the receive stream is framed as BLK_LEN data rows plus a check row.
module blk_parity_codec
    import bpar_pkg::*;
#(
    parameter bit          ODD_SENSE = 1'b1,
    parameter int unsigned BLK_LEN   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_in_valid,
    input  logic [7:0]         tx_in_data,
    output logic               tx_in_ready,
    output logic               tx_out_valid,
    output logic [8:0]         tx_out_row,
    output logic               tx_out_chk,
    input  logic               tx_out_ready,
    input  logic               rx_in_valid,
    input  logic [8:0]         rx_in_row,
    output logic               rx_in_ready,
    output logic               rx_done,
    output logic [BLK_LEN-1:0] rx_row_err,
    output logic [7:0]         rx_col_err,
    output logic               rx_chk_err,
    output logic               rx_any_err
);
    bpar_tx #(.ODD_SENSE(ODD_SENSE), .BLK_LEN(BLK_LEN)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_in_valid),
        .in_data  (tx_in_data),
        .in_ready (tx_in_ready),
        .out_valid(tx_out_valid),
        .out_row  (tx_out_row),
        .out_chk  (tx_out_chk),
        .out_ready(tx_out_ready)
    );

    bpar_rx #(.ODD_SENSE(ODD_SENSE), .BLK_LEN(BLK_LEN)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(rx_in_valid),
        .in_row  (rx_in_row),
        .done    (rx_done),
        .row_err (rx_row_err),
        .col_err (rx_col_err),
        .chk_err (rx_chk_err),
        .any_err (rx_any_err)
    );

    assign rx_in_ready = 1'b1;

    initial begin
        assert_blk_len_R3: assert (BLK_LEN >= 1 && BLK_LEN <= 16);
    end
endmodule

// File: tb/blk_parity_codec_tb_top.sv
`timescale 1ns/1ps
module blk_parity_codec_tb_top;
    localparam int unsigned TB_LEN = 4;
    localparam bit          TB_ODD = 1'b0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_in_valid = 1'b0;
    logic [7:0]        tx_in_data = '0;
    logic              tx_in_ready;
    logic              tx_out_valid;
    logic [8:0]        tx_out_row;
    logic              tx_out_chk;
    logic              tx_out_ready = 1'b1;
    logic              rx_in_valid = 1'b0;
    logic [8:0]        rx_in_row = '0;
    logic              rx_in_ready;
    logic              rx_done;
    logic [TB_LEN-1:0] rx_row_err;
    logic [7:0]        rx_col_err;
    logic              rx_chk_err;
    logic              rx_any_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    blk_parity_codec #(.ODD_SENSE(TB_ODD), .BLK_LEN(TB_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
        .tx_out_valid(tx_out_valid), .tx_out_row(tx_out_row), .tx_out_chk(tx_out_chk),
        .tx_out_ready(tx_out_ready),
        .rx_in_valid(rx_in_valid), .rx_in_row(rx_in_row), .rx_in_ready(rx_in_ready),
        .rx_done(rx_done), .rx_row_err(rx_row_err), .rx_col_err(rx_col_err),
        .rx_chk_err(rx_chk_err), .rx_any_err(rx_any_err)
    );

    always #10 clk = ~clk;

    function automatic logic pbit(input logic [7:0] d);
        return (^d) ^ TB_ODD;
    endfunction

    function automatic logic bad(input logic [8:0] r);
        return (^r) != TB_ODD;
    endfunction

    task automatic note(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Downstream ready pattern with isolated stall cycles.
    int rc = 0;
    always @(posedge clk) begin
        #2;
        rc++;
        tx_out_ready = !((rc % 5) == 1 || (rc % 7) == 3);
    end

    // Transmit monitor and reference model, sampled on the falling edge.
    logic [7:0] q [0:1023];
    int wr = 0, rd = 0, in_cnt = 0, out_cnt = 0, n_data = 0, n_check = 0;
    logic [7:0] col_m = '0;
    bit stall = 1'b0;
    logic [8:0] prev_row = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            wr = 0; rd = 0; in_cnt = 0; out_cnt = 0; col_m = '0; stall = 1'b0;
        end else begin
            if (stall)
                note(tx_out_valid && tx_out_row == prev_row, "R2", "held row",
                     32'(tx_out_row), 32'(prev_row));
            stall = tx_out_valid && !tx_out_ready;
            prev_row = tx_out_row;
            if (tx_out_valid && tx_out_chk) in_cnt = 0;
            if (in_cnt == TB_LEN)
                note(!tx_in_ready, "R3", "in_ready while check due", 32'(tx_in_ready), 32'(0));
            if (tx_in_valid && tx_in_ready) begin
                q[wr] = tx_in_data; wr++; in_cnt++;
            end
            if (tx_out_valid && tx_out_ready) begin
                if (out_cnt == TB_LEN) begin
                    logic [7:0] cb;
                    cb = col_m ^ {8{TB_ODD}};
                    note(tx_out_chk && tx_out_row == {pbit(cb), cb}, "R4", "check row",
                         32'({tx_out_chk, tx_out_row}), 32'({1'b1, pbit(cb), cb}));
                    out_cnt = 0; col_m = '0; n_check++;
                end else begin
                    note(!tx_out_chk && tx_out_row == {pbit(q[rd]), q[rd]}, "R1", "data row",
                         32'({tx_out_chk, tx_out_row}), 32'({1'b0, pbit(q[rd]), q[rd]}));
                    col_m ^= q[rd]; rd++; out_cnt++; n_data++;
                end
            end
        end
    end

    task automatic tx_send(input logic [7:0] d);
        tx_in_valid = 1'b1; tx_in_data = d;
        @(negedge clk);
        while (!tx_in_ready) @(negedge clk);
        @(posedge clk); #2;
        tx_in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    // Receive block under test and its expected report.
    logic [8:0] blk_row [0:TB_LEN-1];
    logic [8:0] blk_chk;

    task automatic build(input int seed);
        logic [7:0] x;
        x = '0;
        for (int k = 0; k < TB_LEN; k++) begin
            logic [7:0] d;
            d = 8'(k * 53 + seed * 29 + 7);
            blk_row[k] = {pbit(d), d};
            x ^= d;
        end
        x ^= {8{TB_ODD}};
        blk_chk = {pbit(x), x};
    endtask

    task automatic rx_run(input string tag, input bit gap);
        logic [TB_LEN-1:0] e_row;
        logic [7:0] e_col;
        logic e_chk, e_any;
        for (int k = 0; k < TB_LEN; k++) begin
            rx_in_valid = 1'b1; rx_in_row = blk_row[k];
            @(posedge clk); #2;
            if (gap) begin rx_in_valid = 1'b0; @(posedge clk); #2; end
        end
        rx_in_valid = 1'b1; rx_in_row = blk_chk;
        @(negedge clk);
        note(!rx_done, "R7", "done before check row", 32'(rx_done), 32'(0));
        @(posedge clk); #2;
        rx_in_valid = 1'b0;
        for (int k = 0; k < TB_LEN; k++) e_row[k] = bad(blk_row[k]);
        for (int c = 0; c < 8; c++) begin
            logic x;
            x = blk_chk[c];
            for (int k = 0; k < TB_LEN; k++) x ^= blk_row[k][c];
            e_col[c] = (x != TB_ODD);
        end
        e_chk = bad(blk_chk);
        e_any = (|e_row) || (|e_col) || e_chk;
        @(negedge clk);
        note(rx_done, "R7", "done pulse", 32'(rx_done), 32'(1));
        note(rx_row_err == e_row, tag, "row errors", 32'(rx_row_err), 32'(e_row));
        note(rx_col_err == e_col, tag, "column errors", 32'(rx_col_err), 32'(e_col));
        note(rx_chk_err == e_chk && rx_any_err == e_any, tag, "check/any flags",
             32'({rx_chk_err, rx_any_err}), 32'({e_chk, e_any}));
        @(negedge clk);
        note(!rx_done && rx_col_err == e_col && rx_row_err == e_row, "R7", "pulse ends, report held",
             32'({rx_done, rx_row_err, rx_col_err}), 32'({1'b0, e_row, e_col}));
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        note(!tx_out_valid && !rx_done && !rx_any_err && rx_row_err == '0 && rx_col_err == '0,
             "R9", "reset state", 32'({tx_out_valid, rx_done, rx_any_err}), 32'(0));
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R1, R2, R3, R4: every character value through the transmit path.
        for (int i = 0; i < 256; i++) begin
            tx_send(8'(i));
            if (i % 9 == 8) idle(1);
        end
        idle(30);
        note(n_data == 256 && n_check == 64, "R3", "rows handed out",
             32'(n_data * 1000 + n_check), 32'(256 * 1000 + 64));

        // R9: abort a partial transmit block by reset.
        tx_send(8'h5A); tx_send(8'hC3);
        idle(8);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) tx_send(8'(i * 17 + 1));
        idle(30);
        note(n_data == 266 && n_check == 66, "R9", "tx rows after abort",
             32'(n_data * 1000 + n_check), 32'(266 * 1000 + 66));

        // R8: clean blocks, with and without idle gaps.
        for (int s = 0; s < 8; s++) begin
            build(s); rx_run("R8", s[0]);
        end
        // R5: every single flip in every data row.
        for (int k = 0; k < TB_LEN; k++)
            for (int b = 0; b < 9; b++) begin
                build(k + b); blk_row[k][b] = ~blk_row[k][b];
                rx_run("R5", 1'b0);
            end
        // R6: every pair of data-bit flips within one row.
        for (int k = 0; k < TB_LEN; k++)
            for (int a = 0; a < 8; a++)
                for (int b = a + 1; b < 8; b++) begin
                    build(a * 8 + b); blk_row[k][a] = ~blk_row[k][a]; blk_row[k][b] = ~blk_row[k][b];
                    rx_run("R6", 1'b0);
                end
        // R10: single flips in the check row.
        for (int b = 0; b < 9; b++) begin
            build(b + 40); blk_chk[b] = ~blk_chk[b];
            rx_run("R10", 1'b0);
        end

        // R9: partial receive block with an error, then reset, then a clean block.
        build(5);
        blk_row[0][2] = ~blk_row[0][2];
        rx_in_valid = 1'b1; rx_in_row = blk_row[0]; @(posedge clk); #2;
        rx_in_row = blk_row[1]; @(posedge clk); #2;
        rx_in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        note(!rx_done, "R9", "no report during abort", 32'(rx_done), 32'(0));
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        note(!rx_done && !rx_any_err, "R9", "cleared after reset", 32'({rx_done, rx_any_err}), 32'(0));
        @(posedge clk); #2;
        build(6); rx_run("R9", 1'b0);

        // R1: even-sense examples through the transmit path.
        for (int i = 0; i < 2; i++) begin
            tx_send(i == 0 ? 8'h01 : 8'h03);
        end
        idle(10);
        note(pbit(8'h01) == 1'b1 && pbit(8'h03) == 1'b0, "R1", "even-sense examples",
             32'({pbit(8'h01), pbit(8'h03)}), 32'(2));

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule